// File: doc/BRIEF.md
# Banked Data Register File with Pointer Indirection

This block is the byte-wide data register file of a small accumulator-style microcontroller. The instruction supplies a 7-bit offset. A bank-select bit held in the status register is placed above that offset to form a full 8-bit address. Most locations hold general-purpose bytes. A few locations are special: a status byte, an indirection pointer, the low byte of the program counter, a port data register and a port direction register.

Offset 0x00 holds no storage. Any access to it is redirected to the full 8-bit address held in the pointer register at offset 0x04, so software can walk through tables and buffers by loading and incrementing the pointer. A write to the program-counter-low location does not store anything. It raises a one-cycle load request toward the fetch logic, which makes computed jumps possible. Reads are combinational from the current state. Writes take effect at the clock edge, so a read-modify-write in one cycle sees the old value. The working accumulator lies outside this file.

Top module: `banked_regfile`

## Requirements
- R1: After reset the status byte is 0x00 (bank 0), the pointer is 0x00, the port data register is 0x00, the port direction register is 0xFF (all pins floating), every general-purpose byte reads 0x00, and `pc_load_o` is low.
- R2: A direct access uses the full address {status bit 5, 7-bit offset}. General-purpose storage sits at offsets 0x20 to 0x2F in each bank, so the same offset reaches a different byte in bank 0 than in bank 1. A write changes only the byte addressed.
- R3: Offset 0x06 reaches the port data register in bank 0 (full address 0x06) and the direction register in bank 1 (0x86). A read of 0x06 returns `pins_i`. A write to it drives `port_out_o`. The direction register drives `port_hiz_o` and reads back its stored value.
- R4: Offsets 0x00, 0x02, 0x03 and 0x04 reach the same function in both banks, so the status byte and the pointer stay reachable whatever the bank bit is.
- R5: Any access to offset 0x00 reads or writes the location whose full 8-bit address is held in the pointer, with the bank bit ignored. The pointer itself is read and written like any other byte.
- R6: When the pointer holds the address of the indirect location itself (0x00 or 0x80), an indirect read returns 0x00 and an indirect write changes nothing.
- R7: In the status byte, bit 0 is carry/borrow, bit 1 is zero and bit 5 is the bank select. A write sets all 8 bits. When `flag_we_i` is high, bits 0 and 1 take `carry_i` and `zero_i` at the clock edge, and this overrides a write to the status byte in the same cycle.
- R8: A write to offset 0x02 raises `pc_load_o` for exactly the following cycle, with `pc_load_data_o` equal to the written byte. A read of offset 0x02 returns `pc_lo_i`.
- R9: Unmapped addresses read as 0x00, and writes to them change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_off_i | input | 7 | Offset field from the instruction |
| wr_en_i | input | 1 | Write the addressed location at the clock edge |
| wr_data_i | input | 8 | Write data |
| rd_data_o | output | 8 | Combinational read data of the addressed location |
| flag_we_i | input | 1 | Update the carry and zero flags from the ALU |
| carry_i | input | 1 | Carry/borrow flag from the ALU |
| zero_i | input | 1 | Zero flag from the ALU |
| pc_lo_i | input | 8 | Current program-counter low byte from fetch |
| pc_load_o | output | 1 | One-cycle request to load the program-counter low byte |
| pc_load_data_o | output | 8 | New program-counter low byte |
| status_o | output | 8 | Status byte (flags and bank bit) |
| pins_i | input | 8 | Sampled port pin levels |
| port_out_o | output | 8 | Port output latch |
| port_hiz_o | output | 8 | Port direction, 1 = pin floating |

## Verification
The bench aims at places where the address path can go wrong. It uses pointer values that name the direction register or the pointer itself from bank 0, so a design that let the bank bit leak into indirect addresses would hit the wrong byte. It points the pointer at 0x00 and 0x80, where a design without the null rule would recurse or write through stale data. It writes the status byte and raises a flag update in the same cycle, which catches the wrong priority. It also checks that the program-counter request lasts exactly one cycle and that the same offset in both banks keeps two separate bytes.

// File: rtl/brf_pkg.sv
package brf_pkg;
  localparam int unsigned DATA_W   = 8;
  localparam int unsigned ADDR_W   = 8;
  localparam int unsigned OFF_W    = 7;
  // Fixed offsets, mirrored in both banks except the port slot
  localparam int unsigned OFF_IND  = 0;
  localparam int unsigned OFF_PCL  = 2;
  localparam int unsigned OFF_STAT = 3;
  localparam int unsigned OFF_PTR  = 4;
  localparam int unsigned OFF_PORT = 6;
  // Status byte layout
  localparam int unsigned ST_CARRY = 0;
  localparam int unsigned ST_ZERO  = 1;
  localparam int unsigned ST_BANK  = 5;

  typedef enum logic [2:0] {
    TGT_NONE, TGT_IND, TGT_PCL, TGT_STAT,
    TGT_PTR,  TGT_PORT, TGT_HIZ, TGT_GPR
  } tgt_e;
endpackage

// File: rtl/brf_decode.sv
module brf_decode
  import brf_pkg::*;
#(
  parameter int unsigned GPR_BASE  = 32,
  parameter int unsigned GPR_DEPTH = 16,
  localparam int unsigned LOC_W    = $clog2(GPR_DEPTH),
  localparam int unsigned IDX_W    = LOC_W + 1
) (
  input  logic              bank_i,
  input  logic [OFF_W-1:0]  off_i,
  input  logic [ADDR_W-1:0] ptr_i,
  output tgt_e              tgt_o,
  output logic [IDX_W-1:0]  gpr_idx_o,
  output logic              via_ptr_o
);
  function automatic tgt_e classify(input logic [ADDR_W-1:0] a);
    logic [OFF_W-1:0] o;
    tgt_e t;
    o = a[OFF_W-1:0];
    if (int'(o) == OFF_IND)       t = TGT_IND;
    else if (int'(o) == OFF_PCL)  t = TGT_PCL;
    else if (int'(o) == OFF_STAT) t = TGT_STAT;
    else if (int'(o) == OFF_PTR)  t = TGT_PTR;
    else if (int'(o) == OFF_PORT) t = a[ADDR_W-1] ? TGT_HIZ : TGT_PORT;
    else if ((int'(o) >= GPR_BASE) && (int'(o) < GPR_BASE + GPR_DEPTH))
      t = TGT_GPR;
    else t = TGT_NONE;
    return t;
  endfunction

  logic [ADDR_W-1:0] dir_addr;
  logic [ADDR_W-1:0] eff_addr;
  logic [OFF_W-1:0]  rel_off;
  tgt_e              tgt_raw;

  always_comb begin
    dir_addr  = {bank_i, off_i};
    via_ptr_o = (classify(dir_addr) == TGT_IND);
    eff_addr  = via_ptr_o ? ptr_i : dir_addr;
    tgt_raw   = classify(eff_addr);
    // A pointer naming the indirect slot itself resolves to nothing
    tgt_o     = (via_ptr_o && tgt_raw == TGT_IND) ? TGT_NONE : tgt_raw;
    rel_off   = eff_addr[OFF_W-1:0] - OFF_W'(GPR_BASE);
    gpr_idx_o = {eff_addr[ADDR_W-1], rel_off[LOC_W-1:0]};
  end
endmodule

// File: rtl/brf_gpr.sv
module brf_gpr #(
  parameter int unsigned DW    = 8,
  parameter int unsigned IDX_W = 5,
  localparam int unsigned N    = 1 << IDX_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic [DW-1:0]    wd_i,
  output logic [DW-1:0]    rd_o
);
  logic [N-1:0][DW-1:0] mem_q, mem_d;

  always_comb begin
    mem_d = mem_q;
    if (we_i) mem_d[idx_i] = wd_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mem_q <= '0;
    else        mem_q <= mem_d;
  end

  assign rd_o = mem_q[idx_i];

  assert_gpr_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    we_i |=> mem_q[$past(idx_i)] == $past(wd_i));
  assert_gpr_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !we_i |=> $stable(mem_q));
endmodule

// File: rtl/brf_special.sv
module brf_special
  import brf_pkg::*;
#(
  parameter int unsigned DW      = 8,
  parameter logic [DW-1:0] HIZ_RST = '1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] wd_i,
  input  logic          we_stat_i,
  input  logic          we_ptr_i,
  input  logic          we_port_i,
  input  logic          we_hiz_i,
  input  logic          we_pcl_i,
  input  logic          flag_we_i,
  input  logic          carry_i,
  input  logic          zero_i,
  output logic [DW-1:0] status_o,
  output logic [DW-1:0] ptr_o,
  output logic [DW-1:0] port_o,
  output logic [DW-1:0] hiz_o,
  output logic          pcl_vld_o,
  output logic [DW-1:0] pcl_data_o
);
  logic [DW-1:0] stat_q, stat_d, ptr_q, ptr_d, port_q, port_d, hiz_q, hiz_d, pcl_q, pcl_d;
  logic          vld_q, vld_d;

  always_comb begin
    stat_d = we_stat_i ? wd_i : stat_q;
    if (flag_we_i) begin
      stat_d[ST_CARRY] = carry_i;
      stat_d[ST_ZERO]  = zero_i;
    end
    ptr_d  = we_ptr_i  ? wd_i : ptr_q;
    port_d = we_port_i ? wd_i : port_q;
    hiz_d  = we_hiz_i  ? wd_i : hiz_q;
    vld_d  = we_pcl_i;
    pcl_d  = we_pcl_i ? wd_i : pcl_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= '0;
      ptr_q  <= '0;
      port_q <= '0;
      hiz_q  <= HIZ_RST;
      vld_q  <= 1'b0;
      pcl_q  <= '0;
    end else begin
      stat_q <= stat_d;
      ptr_q  <= ptr_d;
      port_q <= port_d;
      hiz_q  <= hiz_d;
      vld_q  <= vld_d;
      pcl_q  <= pcl_d;
    end
  end

  assign status_o   = stat_q;
  assign ptr_o      = ptr_q;
  assign port_o     = port_q;
  assign hiz_o      = hiz_q;
  assign pcl_vld_o  = vld_q;
  assign pcl_data_o = pcl_q;

  assert_flag_carry_R7: assert property (@(posedge clk) disable iff (!rst_n)
    flag_we_i |=> (status_o[ST_CARRY] == $past(carry_i)) && (status_o[ST_ZERO] == $past(zero_i)));
  assert_stat_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (we_stat_i && !flag_we_i) |=> status_o == $past(wd_i));
  assert_pcl_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    pcl_vld_o |-> $past(we_pcl_i) && (pcl_data_o == $past(wd_i)));
  assert_pcl_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !we_pcl_i |=> !pcl_vld_o);
endmodule

// File: rtl/banked_regfile.sv
module banked_regfile
  import brf_pkg::*;
#(
  parameter int unsigned GPR_BASE  = 32,
  parameter int unsigned GPR_DEPTH = 16,
  localparam int unsigned IDX_W    = $clog2(GPR_DEPTH) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [OFF_W-1:0]  addr_off_i,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic [DATA_W-1:0] rd_data_o,
  input  logic              flag_we_i,
  input  logic              carry_i,
  input  logic              zero_i,
  input  logic [DATA_W-1:0] pc_lo_i,
  output logic              pc_load_o,
  output logic [DATA_W-1:0] pc_load_data_o,
  output logic [DATA_W-1:0] status_o,
  input  logic [DATA_W-1:0] pins_i,
  output logic [DATA_W-1:0] port_out_o,
  output logic [DATA_W-1:0] port_hiz_o
);
  // Asynchronous assert, synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_int_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  tgt_e              tgt;
  logic [IDX_W-1:0]  gpr_idx;
  logic              via_ptr;
  logic [DATA_W-1:0] ptr_q, gpr_rd;

  brf_decode #(.GPR_BASE(GPR_BASE), .GPR_DEPTH(GPR_DEPTH)) u_dec (
    .bank_i   (status_o[ST_BANK]),
    .off_i    (addr_off_i),
    .ptr_i    (ptr_q),
    .tgt_o    (tgt),
    .gpr_idx_o(gpr_idx),
    .via_ptr_o(via_ptr)
  );

  brf_gpr #(.DW(DATA_W), .IDX_W(IDX_W)) u_gpr (
    .clk  (clk),
    .rst_n(rst_int_n),
    .we_i (wr_en_i && tgt == TGT_GPR),
    .idx_i(gpr_idx),
    .wd_i (wr_data_i),
    .rd_o (gpr_rd)
  );

  brf_special #(.DW(DATA_W), .HIZ_RST('1)) u_spc (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .wd_i      (wr_data_i),
    .we_stat_i (wr_en_i && tgt == TGT_STAT),
    .we_ptr_i  (wr_en_i && tgt == TGT_PTR),
    .we_port_i (wr_en_i && tgt == TGT_PORT),
    .we_hiz_i  (wr_en_i && tgt == TGT_HIZ),
    .we_pcl_i  (wr_en_i && tgt == TGT_PCL),
    .flag_we_i (flag_we_i),
    .carry_i   (carry_i),
    .zero_i    (zero_i),
    .status_o  (status_o),
    .ptr_o     (ptr_q),
    .port_o    (port_out_o),
    .hiz_o     (port_hiz_o),
    .pcl_vld_o (pc_load_o),
    .pcl_data_o(pc_load_data_o)
  );

  always_comb begin
    unique case (tgt)
      TGT_PCL:  rd_data_o = pc_lo_i;
      TGT_STAT: rd_data_o = status_o;
      TGT_PTR:  rd_data_o = ptr_q;
      TGT_PORT: rd_data_o = pins_i;
      TGT_HIZ:  rd_data_o = port_hiz_o;
      TGT_GPR:  rd_data_o = gpr_rd;
      default:  rd_data_o = '0;
    endcase
  end

  // R6: a pointer naming the indirect slot yields zero read data
  assert_null_ind_R6: assert property (@(posedge clk) disable iff (!rst_int_n)
    (via_ptr && ptr_q[OFF_W-1:0] == OFF_W'(OFF_IND)) |-> rd_data_o == '0);
  // R5: indirect access ignores the bank bit, so the port slot follows the pointer's top bit
  assert_ind_bank_R5: assert property (@(posedge clk) disable iff (!rst_int_n)
    (via_ptr && ptr_q[OFF_W-1:0] == OFF_W'(OFF_PORT)) |-> rd_data_o == (ptr_q[ADDR_W-1] ? port_hiz_o : pins_i));
  // R4: the status slot reads the same byte in either bank
  assert_stat_mirror_R4: assert property (@(posedge clk) disable iff (!rst_int_n)
    (addr_off_i == OFF_W'(OFF_STAT)) |-> rd_data_o == status_o);
endmodule

// File: tb/tb_banked_regfile.sv
module tb_banked_regfile;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [6:0] addr_off_i;
  logic       wr_en_i;
  logic [7:0] wr_data_i;
  logic [7:0] rd_data_o;
  logic       flag_we_i, carry_i, zero_i;
  logic [7:0] pc_lo_i;
  logic       pc_load_o;
  logic [7:0] pc_load_data_o, status_o, pins_i, port_out_o, port_hiz_o;

  always #2 clk = ~clk;

  banked_regfile dut (.*);

  // Reference state
  logic [7:0] m_gpr [32];
  logic [7:0] m_st, m_ptr, m_port, m_hiz, m_pcl_d;
  logic       m_pcl_v;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  // kinds: 0 none,1 ind,2 pcl,3 stat,4 ptr,5 port,6 hiz,7 gpr
  function automatic int kind_of(input logic [7:0] a);
    logic [6:0] o = a[6:0];
    if (o == 7'h00) return 1;
    if (o == 7'h02) return 2;
    if (o == 7'h03) return 3;
    if (o == 7'h04) return 4;
    if (o == 7'h06) return a[7] ? 6 : 5;
    if (o >= 7'h20 && o <= 7'h2F) return 7;
    return 0;
  endfunction

  function automatic logic [7:0] eff_addr(input logic [6:0] off);
    logic [7:0] a = {m_st[5], off};
    return (kind_of(a) == 1) ? m_ptr : a;
  endfunction

  function automatic int eff_kind(input logic [6:0] off);
    logic [7:0] a = {m_st[5], off};
    int k = kind_of(a);
    if (k == 1) begin
      k = kind_of(m_ptr);
      if (k == 1) k = 0;
    end
    return k;
  endfunction

  function automatic string tag_of(input logic [6:0] off);
    int k = eff_kind(off);
    if (kind_of({m_st[5], off}) == 1) return (k == 0) ? "R6" : "R5";
    case (k)
      2: return "R8";
      3: return "R4";
      4: return "R4";
      5, 6: return "R3";
      7: return "R2";
      default: return "R9";
    endcase
  endfunction

  function automatic logic [7:0] exp_read(input logic [6:0] off);
    logic [7:0] a = eff_addr(off);
    case (eff_kind(off))
      2: return pc_lo_i;
      3: return m_st;
      4: return m_ptr;
      5: return pins_i;
      6: return m_hiz;
      7: return m_gpr[{a[7], a[3:0]}];
      default: return 8'h00;
    endcase
  endfunction

  task automatic check(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %02h expected %02h", req, what, act, exp);
    end
  endtask

  task automatic step(input bit w, input logic [6:0] off, input logic [7:0] d,
                      input bit fw, input bit c, input bit z);
    int k;
    logic [7:0] a;
    @(negedge clk);
    addr_off_i = off; wr_en_i = w; wr_data_i = d;
    flag_we_i = fw; carry_i = c; zero_i = z;
    pc_lo_i = 8'($urandom); pins_i = 8'($urandom);
    #1;
    check(tag_of(off), "read", rd_data_o, exp_read(off));
    check("R7", "status", status_o, m_st);
    check("R3", "port_out", port_out_o, m_port);
    check("R3", "port_hiz", port_hiz_o, m_hiz);
    check("R8", "pc_load", {7'b0, pc_load_o}, {7'b0, m_pcl_v});
    if (m_pcl_v) check("R8", "pc_load_data", pc_load_data_o, m_pcl_d);
    k = eff_kind(off);
    a = eff_addr(off);
    @(posedge clk);
    m_pcl_v = w && (k == 2);
    if (m_pcl_v) m_pcl_d = d;
    if (w) begin
      case (k)
        3: m_st = d;
        4: m_ptr = d;
        5: m_port = d;
        6: m_hiz = d;
        7: m_gpr[{a[7], a[3:0]}] = d;
        default: ;
      endcase
    end
    if (fw) begin m_st[0] = c; m_st[1] = z; end
  endtask

  task automatic rd(input logic [6:0] off);
    step(0, off, 8'h00, 0, 0, 0);
  endtask
  task automatic wr(input logic [6:0] off, input logic [7:0] d);
    step(1, off, d, 0, 0, 0);
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    rst_n = 1'b0;
    addr_off_i = '0; wr_en_i = 0; wr_data_i = '0;
    flag_we_i = 0; carry_i = 0; zero_i = 0; pc_lo_i = '0; pins_i = '0;
    foreach (m_gpr[i]) m_gpr[i] = 8'h00;
    m_st = 0; m_ptr = 0; m_port = 0; m_hiz = 8'hFF; m_pcl_v = 0; m_pcl_d = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);

    // R1 reset state
    @(negedge clk); #1;
    check("R1", "status reset", status_o, 8'h00);
    check("R1", "hiz reset", port_hiz_o, 8'hFF);
    check("R1", "port reset", port_out_o, 8'h00);
    check("R1", "pc_load reset", {7'b0, pc_load_o}, 8'h00);
    rd(7'h04); rd(7'h20); rd(7'h2F);

    // R2 same offset, two banks
    wr(7'h25, 8'h11);
    wr(7'h03, 8'h20);
    rd(7'h25);
    wr(7'h25, 8'h22);
    rd(7'h03);
    wr(7'h03, 8'h00);
    rd(7'h25);

    // R3 port and direction
    wr(7'h06, 8'hA5); rd(7'h06);
    wr(7'h03, 8'h20);
    wr(7'h06, 8'h0F); rd(7'h06);
    rd(7'h04);  // R4 pointer mirrored in bank 1
    wr(7'h03, 8'h00);

    // R5 indirect ignores bank: pointer names bank-1 byte while in bank 0
    wr(7'h04, 8'hA5); wr(7'h00, 8'h5A); rd(7'h00);
    wr(7'h04, 8'h86); rd(7'h00); wr(7'h00, 8'h3C); rd(7'h00);
    wr(7'h04, 8'h04); wr(7'h00, 8'h21); rd(7'h00); rd(7'h04);
    // increment the pointer through read-modify-write
    rd(7'h04); wr(7'h04, 8'h22); rd(7'h04);

    // R6 null pointer
    wr(7'h04, 8'h00); wr(7'h00, 8'hFF); rd(7'h00);
    wr(7'h04, 8'h80); wr(7'h00, 8'hEE); rd(7'h00); rd(7'h03);

    // R7 status write and flag update together
    step(1, 7'h03, 8'hFC, 1, 1, 1); rd(7'h03);
    step(1, 7'h03, 8'h03, 1, 0, 0); rd(7'h03);
    step(0, 7'h20, 8'h00, 1, 1, 0); rd(7'h03);
    wr(7'h03, 8'h00);

    // R8 program counter low
    wr(7'h02, 8'h7B); rd(7'h02); rd(7'h02);
    wr(7'h02, 8'h10); wr(7'h02, 8'h11); rd(7'h02);

    // R9 unmapped
    wr(7'h01, 8'h99); rd(7'h01); wr(7'h7F, 8'h42); rd(7'h7F); rd(7'h30);

    // Random traffic
    for (int i = 0; i < 4000; i++) begin
      logic [6:0] off;
      int sel = $urandom_range(0, 9);
      case (sel)
        0: off = 7'h00;
        1: off = 7'h02;
        2: off = 7'h03;
        3: off = 7'h04;
        4: off = 7'h06;
        5: off = 7'($urandom);
        default: off = 7'h20 + 7'($urandom_range(0, 15));
      endcase
      if (off == 7'h04 && ($urandom_range(0, 1) == 1))
        step(1, off, {1'($urandom), 3'b0, 4'($urandom_range(0, 7))}, 0, 0, 0);
      else
        step($urandom_range(0, 2) != 0, off, 8'($urandom),
             $urandom_range(0, 3) == 0, 1'($urandom), 1'($urandom));
    end

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule